// File: doc/BRIEF.md
# General-Purpose Event Status/Enable Register Block

This block holds a small bank of general-purpose event bits behind a fixed four-byte window on a byte-addressed I/O bus. Half of the window is a status half: a rising edge on a hardware event input latches the matching status bit, and software clears latched bits by writing ones to them. The other half is an enable half, plain read/write, whose bit n pairs with status bit n.

A single level interrupt request is raised whenever any status bit is set while its enable bit is also set. The request follows the register contents, so it is re-evaluated after every write and after every latched event. It drops as soon as software clears the last enabled pending bit or removes its enable.

Bus accesses carry a start address and up to four byte enables. Byte lane k of the data bus refers to the start address plus k (little-endian), and each lane is handled as its own single-byte access. Lanes that fall outside the window are not claimed, read as zero and have no effect on a write.

Top module: `gpe_regblock`

## Requirements
- R1: After reset every status and enable bit reads 0 and the interrupt output is low.
- R2: The window is four bytes starting at I/O address 0xAFE0: offset 0 holds status bits 7:0, offset 1 status bits 15:8, offset 2 enable bits 7:0 and offset 3 enable bits 15:8. A read returns these bytes on the same cycle the access is presented.
- R3: Byte lane k (data bits 8k+7:8k) addresses start address + k; only lanes whose byte enable is 1 take part, and a read returns 0 on every other lane.
- R4: A 0-to-1 transition of event input n sets status bit n at the next clock edge; an input held high sets the bit only once, so after software clears it the bit stays 0.
- R5: Writing a 1 to a status bit clears it at the clock edge of the write; writing 0 leaves the bit unchanged.
- R6: When an event edge and a software clear hit the same status bit at the same clock edge, the bit ends up set.
- R7: Enable bytes store the written byte at the clock edge of the write and read back unchanged; only the bytes written change.
- R8: The interrupt output equals the OR over all n of (status n AND enable n), a level that changes only as a result of a clock edge that changes status or enable.
- R9: The hit output is 1 only when at least one enabled lane falls inside the window; with hit low the read data is 0 and a write changes nothing.
- R10: An access that straddles the window edge acts only on the lanes that fall inside it, e.g. a four-lane access at 0xAFE2 touches the enable bytes on lanes 0 and 1 and ignores lanes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of lane 0 |
| bus_be | input | 4 | Byte enables, one per lane |
| bus_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| bus_rdata | output | 32 | Read data, zero on lanes not claimed |
| bus_hit | output | 1 | Access claimed by the block |
| evt_in | input | 16 | Event inputs, one per status bit |
| sci_o | output | 1 | Level interrupt request |

## Verification
Read data and the hit flag are due in the same cycle the access is presented, so the scoreboard's monitor samples them at the falling edge of that cycle, half a period after the driver changed the inputs. Writes and event edges take effect at the next rising edge, and the interrupt level follows one edge after the stimulus; the bench model applies each write and each event edge only after that edge has passed, so the next read, which also carries the expected interrupt level, sees the updated state. The set-over-clear case is driven by presenting an event edge and a clearing write in the very same cycle.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  // Offset of a lane's byte from the window base, one bit wider than the
  // address so that an address below the base wraps to a large value.
  function automatic logic [16:0] lane_offset(input logic [15:0] addr,
                                              input int unsigned lane,
                                              input logic [15:0] base);
    lane_offset = {1'b0, addr} + 17'(lane) - {1'b0, base};
  endfunction
endpackage

// File: rtl/gpe_lane_decode.sv
module gpe_lane_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned NUM_BYTES = 4,
  parameter logic [15:0] BASE      = 16'hAFE0,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                 bus_sel,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_BYTES-1:0] bus_be,
  output logic [BUS_BYTES-1:0] lane_hit,
  output logic [IDX_W-1:0]     lane_idx [BUS_BYTES]
);
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    logic [16:0] off;
    assign off         = gpe_pkg::lane_offset(16'(bus_addr), k, BASE);
    assign lane_hit[k] = bus_sel && bus_be[k] && (off < 17'(NUM_BYTES));
    assign lane_idx[k] = off[IDX_W-1:0];
  end
endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank #(
  parameter int unsigned EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] sts,
  output logic [EVT_W-1:0] rise
);
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] sts_nxt;
  logic             sts_ce;

  always_comb begin
    rise    = evt_in & ~evt_q;
    sts_ce  = (|rise) || (|clr_mask);
    sts_nxt = (sts & ~clr_mask) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      sts   <= '0;
    end else begin
      evt_q <= evt_in;
      if (sts_ce) sts <= sts_nxt;
    end
  end

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~rise)) |=> ((sts & $past(clr_mask & ~rise)) == '0));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((sts & $past(rise)) == $past(rise)));
  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(rise)) == '0));
endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank #(
  parameter int unsigned HALF_BYTES = 2,
  localparam int unsigned EVT_W     = 8 * HALF_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HALF_BYTES-1:0] wr_stb,
  input  logic [7:0]            wr_byte [HALF_BYTES],
  output logic [EVT_W-1:0]      en
);
  logic [EVT_W-1:0] en_nxt;

  always_comb begin
    en_nxt = en;
    for (int j = 0; j < HALF_BYTES; j++)
      if (wr_stb[j]) en_nxt[8*j +: 8] = wr_byte[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= '0;
    else if (|wr_stb) en <= en_nxt;
  end

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_stb) |=> $stable(en));
endmodule

// File: rtl/gpe_regblock.sv
module gpe_regblock #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BUS_BYTES  = 4,
  parameter int unsigned HALF_BYTES = 2,
  parameter logic [15:0] BASE       = 16'hAFE0,
  localparam int unsigned NUM_BYTES = 2 * HALF_BYTES,
  localparam int unsigned EVT_W     = 8 * HALF_BYTES,
  localparam int unsigned DATA_W    = 8 * BUS_BYTES,
  localparam int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_BYTES-1:0] bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_hit,
  input  logic [EVT_W-1:0]     evt_in,
  output logic                 sci_o
);
  logic [BUS_BYTES-1:0]  lane_hit;
  logic [IDX_W-1:0]      lane_idx [BUS_BYTES];
  logic [NUM_BYTES-1:0]  byte_stb;
  logic [7:0]            byte_wd  [NUM_BYTES];
  logic [7:0]            byte_rd  [NUM_BYTES];
  logic [EVT_W-1:0]      clr_mask;
  logic [EVT_W-1:0]      sts;
  logic [EVT_W-1:0]      en;
  logic [EVT_W-1:0]      rise;
  logic [HALF_BYTES-1:0] en_stb;
  logic [7:0]            en_wd    [HALF_BYTES];

  gpe_lane_decode #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .NUM_BYTES(NUM_BYTES), .BASE(BASE)
  ) u_dec (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_be(bus_be),
    .lane_hit(lane_hit), .lane_idx(lane_idx)
  );

  // Route each claimed write lane to its register byte.
  always_comb begin
    for (int j = 0; j < NUM_BYTES; j++) begin
      byte_stb[j] = 1'b0;
      byte_wd[j]  = '0;
      for (int k = 0; k < BUS_BYTES; k++)
        if (bus_wr && lane_hit[k] && lane_idx[k] == IDX_W'(j)) begin
          byte_stb[j] = 1'b1;
          byte_wd[j]  = bus_wdata[8*k +: 8];
        end
    end
  end

  for (genvar j = 0; j < HALF_BYTES; j++) begin : g_half
    assign clr_mask[8*j +: 8]    = byte_stb[j] ? byte_wd[j] : 8'h00;
    assign en_stb[j]             = byte_stb[HALF_BYTES + j];
    assign en_wd[j]              = byte_wd[HALF_BYTES + j];
    assign byte_rd[j]            = sts[8*j +: 8];
    assign byte_rd[HALF_BYTES+j] = en[8*j +: 8];
  end

  gpe_status_bank #(.EVT_W(EVT_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_mask(clr_mask),
    .sts(sts), .rise(rise)
  );

  gpe_enable_bank #(.HALF_BYTES(HALF_BYTES)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_stb(en_stb), .wr_byte(en_wd), .en(en)
  );

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_rd
    assign bus_rdata[8*k +: 8] = lane_hit[k] ? byte_rd[lane_idx[k]] : 8'h00;
  end

  assign bus_hit = |lane_hit;
  assign sci_o   = |(sts & en);

  // R9
  unclaimed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (bus_rdata == '0));
  // R8
  sci_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci_o) |-> $past((|rise) || (|en_stb)));
  // R8
  sci_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sci_o) |-> $past((|clr_mask) || (|en_stb)));
endmodule

// File: tb/gpe_regblock_test.sv
module gpe_regblock_test;
  localparam logic [15:0] BASE = 16'hAFE0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_hit, sci_o;
  logic [15:0] evt_in;

  gpe_regblock uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit), .evt_in(evt_in), .sci_o(sci_o)
  );

  always #10 clk = ~clk;

  typedef struct { logic [31:0] rd; logic hit; logic sci; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] sts_m = '0, en_m = '0, evt_prev = '0;

  function automatic logic [7:0] m_byte(int j);
    return (j < 2) ? sts_m[8*j +: 8] : en_m[8*(j-2) +: 8];
  endfunction

  // One bus cycle, entered just after a rising edge.
  task automatic cyc(bit sel, bit wr, logic [15:0] a, logic [3:0] be,
                     logic [31:0] wd, logic [15:0] ev, string tag);
    exp_t e;
    logic [15:0] clr = '0;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    evt_in = ev;
    if (sel && !wr) begin
      e.rd = '0; e.hit = 1'b0; e.tag = tag;
      for (int k = 0; k < 4; k++) begin
        int off = int'(a) + k - int'(BASE);
        if (be[k] && off >= 0 && off < 4) begin
          e.rd[8*k +: 8] = m_byte(off);
          e.hit = 1'b1;
        end
      end
      e.sci = |(sts_m & en_m);
      q.push_back(e);
    end
    @(posedge clk); #1;
    if (sel && wr)
      for (int k = 0; k < 4; k++) begin
        int off = int'(a) + k - int'(BASE);
        if (be[k] && off >= 0 && off < 4) begin
          if (off < 2) clr[8*off +: 8] = wd[8*k +: 8];
          else en_m[8*(off-2) +: 8] = wd[8*k +: 8];
        end
      end
    sts_m = (sts_m & ~clr) | (ev & ~evt_prev);
    evt_prev = ev;
    bus_sel = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [3:0] be, string tag);
    cyc(1, 0, a, be, 32'h0, evt_in, tag);
  endtask
  task automatic wr(logic [15:0] a, logic [3:0] be, logic [31:0] d, string tag);
    cyc(1, 1, a, be, d, evt_in, tag);
  endtask
  task automatic ev(logic [15:0] v);
    cyc(0, 0, 16'h0, 4'h0, 32'h0, v, "");
  endtask

  // Monitor: compare read results in the middle of the cycle.
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      exp_t e;
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: rdata=%h hit=%b", bus_rdata, bus_hit);
      end else begin
        e = q.pop_front();
        if (bus_rdata !== e.rd || bus_hit !== e.hit || sci_o !== e.sci) begin
          fails++;
          $display("FAIL %s: rdata=%h hit=%b sci=%b expected rdata=%h hit=%b sci=%b",
                   e.tag, bus_rdata, bus_hit, sci_o, e.rd, e.hit, e.sci);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_be = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    rd(BASE, 4'hF, "R1 reset state");
    tests++;
    if (sci_o !== 1'b0) begin
      fails++; $display("FAIL R1 sci after reset: actual %b expected 0", sci_o);
    end

    wr(BASE + 16'd2, 4'b0011, 32'h0000_1234, "R7 enable write");
    rd(BASE, 4'hF, "R7 R2 enable readback");
    rd(BASE, 4'b0100, "R3 single lane read");

    ev(16'h0010); ev(16'h0000);
    rd(BASE, 4'hF, "R4 event sets status, R8 sci high");
    ev(16'h0001); ev(16'h0000);
    rd(BASE, 4'b0001, "R4 second event");

    wr(BASE, 4'b0001, 32'h0000_0010, "R5 clear bit4");
    rd(BASE, 4'hF, "R5 w1c leaves bit0, R8 sci low");
    wr(BASE, 4'b0001, 32'h0000_0000, "R5 zero write");
    rd(BASE, 4'b0011, "R5 zero write no change");

    ev(16'h0200);
    wr(BASE, 4'b0010, 32'h0000_0200, "R4 clear held event");
    rd(BASE, 4'b0011, "R4 held input does not reset bit");
    ev(16'h0000);

    wr(BASE + 16'd2, 4'b0001, 32'h0000_0001, "R8 enable bit0");
    rd(BASE, 4'hF, "R8 sci from bit0");
    cyc(1, 1, BASE, 4'b0001, 32'h0000_0001, 16'h0001, "R6 set and clear");
    rd(BASE, 4'hF, "R6 set wins");
    ev(16'h0000);
    wr(BASE + 16'd2, 4'b0011, 32'h0000_0000, "R8 disable all");
    rd(BASE, 4'hF, "R8 sci drops with enable");

    rd(BASE - 16'd4, 4'hF, "R9 below window");
    rd(BASE + 16'd4, 4'hF, "R9 above window");
    rd(BASE - 16'd2, 4'hF, "R3 R10 straddle low");
    rd(BASE, 4'h0, "R9 no byte enables");
    wr(BASE + 16'd4, 4'hF, 32'hFFFF_FFFF, "R9 write outside");
    wr(BASE - 16'd4, 4'hF, 32'hFFFF_FFFF, "R9 write below");
    rd(BASE, 4'hF, "R9 outside write had no effect");
    wr(BASE + 16'd2, 4'hF, 32'hAAAA_8001, "R10 straddle write");
    rd(BASE, 4'hF, "R10 only enable lanes written, R8 sci");
    rd(BASE + 16'd3, 4'hF, "R3 lane0 at offset 3");

    @(posedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule